// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of address translations. Each slot holds a valid flag, an address-space tag, a virtual page number, a physical frame number and a read-only flag. A lookup presents a page number, the tag of the running process and a write flag. One cycle later the block reports one of three outcomes: a hit with its frame number, a miss, or a protection fault.

After a miss, the page-table walker (outside this block) installs the pair through the fill port. The slot for a fill is chosen in this order: a slot that already holds the same page and tag, then the lowest-numbered empty slot, then the slot under a round-robin pointer. A full flush empties the cache. A tagged flush empties only the slots of one address space. A build-time switch turns tag matching off. In that mode the tag is ignored and a context-switch pulse empties the cache.

Top module: `tlb_asid_cache`

## Requirements
- R1: After reset every slot is empty, `rsp_valid` is low, and any lookup reports a miss.
- R2: A response appears exactly one cycle after each lookup request (`rsp_valid` high in that cycle only), with exactly one of `rsp_hit`, `rsp_miss`, `rsp_fault` set. State changes made in the cycle of the request do not affect it.
- R3: A lookup whose page number matches a valid slot with the same tag reports a hit and returns that slot's frame number. On a miss or fault `rsp_pfn` is zero.
- R4: With tag matching on (`USE_ASID=1`), a slot whose tag differs from the lookup tag never hits, and the lookup reports a miss.
- R5: A write lookup that matches a read-only slot reports a fault and no hit. A read lookup of the same slot hits.
- R6: A fill whose page and tag match no slot goes to the lowest-numbered empty slot when one exists.
- R7: When all slots are full, a new fill replaces the slot under a round-robin pointer. The pointer starts at slot 0 after reset, advances by one (wrapping) on each such replacement, and is not moved by flushes.
- R8: A fill whose page number and tag match a valid slot overwrites that slot, so no duplicate is created and no other slot is displaced.
- R9: `flush_all` empties every slot. A fill in the same cycle is dropped.
- R10: With tag matching on, `flush_asid_valid` empties exactly the slots whose tag equals `flush_asid`. A fill in the same cycle is dropped.
- R11: With `USE_ASID=0`, tags are ignored for matching and `ctx_switch` empties every slot. With `USE_ASID=1`, `ctx_switch` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Tag of the running process |
| lk_write | input | 1 | Lookup is for a write access |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation found and access allowed |
| rsp_miss | output | 1 | No matching slot |
| rsp_fault | output | 1 | Write to a read-only page |
| rsp_pfn | output | PFN_W | Frame number on hit, zero otherwise |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page number to install |
| fill_asid | input | ASID_W | Tag to install |
| fill_pfn | input | PFN_W | Frame number to install |
| fill_ro | input | 1 | Installed page is read-only |
| flush_all | input | 1 | Empty every slot |
| flush_asid_valid | input | 1 | Empty the slots of one tag |
| flush_asid | input | ASID_W | Tag for the targeted flush |
| ctx_switch | input | 1 | Context switch (flushes only without tags) |

## Verification
On every cycle the assertions check the response contract: the one-cycle latency, exactly one outcome, a zero frame on a non-hit, and a fault only on a write. They also check that a lookup never matches two slots, that a fill with an empty slot available never lands on an occupied one, and that no slot becomes valid in the cycle after a flush. Some behaviour only the bench's scenarios can show: which frame comes back, the order in which slots are reused, what a tagged flush leaves in place, and how the untagged build behaves. The bench shows these with directed fill, flush and lookup sequences, checked against a slot model it keeps from the requirements.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    RES_MISS  = 2'd0,
    RES_HIT   = 2'd1,
    RES_FAULT = 2'd2
  } tlb_result_e;

  // Outcome of one lookup, given whether a slot matched and its protection.
  function automatic tlb_result_e classify(input logic matched,
                                           input logic is_write,
                                           input logic read_only);
    if (!matched)              return RES_MISS;
    if (is_write && read_only) return RES_FAULT;
    return RES_HIT;
  endfunction

endpackage

// File: rtl/tlb_match.sv
// Parallel tag/page comparison against every slot.
module tlb_match #(
  parameter int ENTRIES  = 8,
  parameter int VPN_W    = 20,
  parameter int ASID_W   = 8,
  parameter bit USE_ASID = 1'b1
) (
  input  logic [ENTRIES-1:0]             ent_valid,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
  input  logic [ENTRIES-1:0][ASID_W-1:0] ent_asid,
  input  logic [VPN_W-1:0]               q_vpn,
  input  logic [ASID_W-1:0]              q_asid,
  output logic [ENTRIES-1:0]             hit_vec
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic tag_ok;
    if (USE_ASID) begin : g_tagged
      assign tag_ok = (ent_asid[g] == q_asid);
    end else begin : g_untagged
      assign tag_ok = 1'b1;
    end
    assign hit_vec[g] = ent_valid[g] && (ent_vpn[g] == q_vpn) && tag_ok;
  end

endmodule

// File: rtl/tlb_victim.sv
// Chooses the lowest empty slot, else the round-robin slot.
module tlb_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [IDX_W-1:0]   rr_ptr,
  output logic               any_free,
  output logic [IDX_W-1:0]   free_idx,
  output logic [IDX_W-1:0]   victim_idx
);

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) free_idx = IDX_W'(i);
    end
  end

  assign any_free   = ~&valid_vec;
  assign victim_idx = any_free ? free_idx : rr_ptr;

endmodule

// File: rtl/tlb_asid_cache.sv
module tlb_asid_cache
  import tlb_pkg::*;
#(
  parameter int ENTRIES  = 8,
  parameter int VPN_W    = 20,
  parameter int PFN_W    = 16,
  parameter int ASID_W   = 8,
  parameter bit USE_ASID = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_write,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_fault,
  output logic [PFN_W-1:0]  rsp_pfn,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              fill_ro,
  input  logic              flush_all,
  input  logic              flush_asid_valid,
  input  logic [ASID_W-1:0] flush_asid,
  input  logic              ctx_switch
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  // Slot storage
  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
  logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q;
  logic [ENTRIES-1:0]             ro_q;
  logic [IDX_W-1:0]               rr_ptr_q;

  // Named internal events
  logic               flush_every;
  logic               flush_tag;
  logic               fill_evt;
  logic               fill_reuse;
  logic               fill_evict;
  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] fill_match;
  logic               any_free;
  logic [IDX_W-1:0]   free_idx;
  logic [IDX_W-1:0]   victim_idx;
  logic [IDX_W-1:0]   reuse_idx;
  logic [IDX_W-1:0]   fill_idx;

  function automatic logic [IDX_W-1:0] onehot_index(input logic [ENTRIES-1:0] vec);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (vec[i]) idx = IDX_W'(i);
    end
    return idx;
  endfunction

  tlb_match #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .USE_ASID(USE_ASID)
  ) u_lookup_match (
    .ent_valid(valid_q), .ent_vpn(vpn_q), .ent_asid(asid_q),
    .q_vpn(lk_vpn), .q_asid(lk_asid), .hit_vec(lk_match)
  );

  tlb_match #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .USE_ASID(USE_ASID)
  ) u_fill_match (
    .ent_valid(valid_q), .ent_vpn(vpn_q), .ent_asid(asid_q),
    .q_vpn(fill_vpn), .q_asid(fill_asid), .hit_vec(fill_match)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .valid_vec(valid_q), .rr_ptr(rr_ptr_q),
    .any_free(any_free), .free_idx(free_idx), .victim_idx(victim_idx)
  );

  assign flush_every = flush_all || (!USE_ASID && ctx_switch);
  assign flush_tag   = USE_ASID && flush_asid_valid && !flush_every;
  assign fill_evt    = fill_valid && !flush_every && !flush_tag;
  assign fill_reuse  = |fill_match;
  assign reuse_idx   = onehot_index(fill_match);
  assign fill_idx    = fill_reuse ? reuse_idx : victim_idx;
  assign fill_evict  = fill_evt && !fill_reuse && !any_free;

  // Slot update
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= '0;
      vpn_q    <= '0;
      asid_q   <= '0;
      pfn_q    <= '0;
      ro_q     <= '0;
      rr_ptr_q <= '0;
    end else begin
      if (flush_every) begin
        valid_q <= '0;
      end else if (flush_tag) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (asid_q[i] == flush_asid) valid_q[i] <= 1'b0;
        end
      end else if (fill_evt) begin
        valid_q[fill_idx] <= 1'b1;
        vpn_q[fill_idx]   <= fill_vpn;
        asid_q[fill_idx]  <= fill_asid;
        pfn_q[fill_idx]   <= fill_pfn;
        ro_q[fill_idx]    <= fill_ro;
      end
      if (fill_evict) begin
        rr_ptr_q <= (rr_ptr_q == LAST_IDX) ? '0 : rr_ptr_q + 1'b1;
      end
    end
  end

  // Lookup read-out and registered response
  logic             lk_any;
  logic             lk_ro;
  logic [PFN_W-1:0] lk_pfn;
  tlb_result_e      lk_res;

  always_comb begin
    lk_ro  = 1'b0;
    lk_pfn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        lk_ro  = lk_ro | ro_q[i];
        lk_pfn = lk_pfn | pfn_q[i];
      end
    end
  end

  assign lk_any = |lk_match;
  assign lk_res = classify(lk_any, lk_write, lk_ro);

  tlb_result_e      res_q;
  logic             rsp_valid_q;
  logic [PFN_W-1:0] rsp_pfn_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      res_q       <= RES_MISS;
      rsp_pfn_q   <= '0;
    end else begin
      rsp_valid_q <= lk_valid;
      if (lk_valid) begin
        res_q     <= lk_res;
        rsp_pfn_q <= (lk_res == RES_HIT) ? lk_pfn : '0;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_valid_q && (res_q == RES_HIT);
  assign rsp_miss  = rsp_valid_q && (res_q == RES_MISS);
  assign rsp_fault = rsp_valid_q && (res_q == RES_FAULT);
  assign rsp_pfn   = rsp_valid_q ? rsp_pfn_q : '0;

  // Assertions
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);

  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);

  a_r3_zero_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> rsp_pfn == '0);

  a_r5_fault_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> $past(lk_write));

  a_r8_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $onehot0(lk_match));

  a_r6_free_first: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_evt && !fill_reuse && any_free) |-> !valid_q[fill_idx]);

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_every |=> valid_q == '0);

  a_r10_nothing_new: assert property (@(posedge clk) disable iff (!rst_n)
    flush_tag |=> (valid_q & ~$past(valid_q)) == '0);

endmodule

// File: tb/test_tlb_asid_cache.sv
`timescale 1ns/1ps
module test_tlb_asid_cache;

  localparam int N = 8;
  localparam int VPN_W = 20, PFN_W = 16, ASID_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              lk_valid = 0, lk_write = 0;
  logic [VPN_W-1:0]  lk_vpn = '0;
  logic [ASID_W-1:0] lk_asid = '0;
  logic              fill_valid = 0, fill_ro = 0;
  logic [VPN_W-1:0]  fill_vpn = '0;
  logic [ASID_W-1:0] fill_asid = '0;
  logic [PFN_W-1:0]  fill_pfn = '0;
  logic              flush_all = 0, flush_asid_valid = 0, ctx_switch = 0;
  logic [ASID_W-1:0] flush_asid = '0;

  logic             rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [PFN_W-1:0] rsp_pfn;
  logic             n_valid, n_hit, n_miss, n_fault;
  logic [PFN_W-1:0] n_pfn;

  tlb_asid_cache #(.ENTRIES(N), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W),
                   .USE_ASID(1'b1)) i_tlb_asid_cache (
    .clk, .rst_n, .lk_valid, .lk_vpn, .lk_asid, .lk_write,
    .rsp_valid, .rsp_hit, .rsp_miss, .rsp_fault, .rsp_pfn,
    .fill_valid, .fill_vpn, .fill_asid, .fill_pfn, .fill_ro,
    .flush_all, .flush_asid_valid, .flush_asid, .ctx_switch);

  tlb_asid_cache #(.ENTRIES(N), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W),
                   .USE_ASID(1'b0)) i_tlb_asid_cache_untagged (
    .clk, .rst_n, .lk_valid, .lk_vpn, .lk_asid, .lk_write,
    .rsp_valid(n_valid), .rsp_hit(n_hit), .rsp_miss(n_miss),
    .rsp_fault(n_fault), .rsp_pfn(n_pfn),
    .fill_valid, .fill_vpn, .fill_asid, .fill_pfn, .fill_ro,
    .flush_all, .flush_asid_valid, .flush_asid, .ctx_switch);

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // Slot model for the tagged instance, kept from the requirements
  bit              m_v [N];
  bit [VPN_W-1:0]  m_vpn [N];
  bit [ASID_W-1:0] m_asid [N];
  bit [PFN_W-1:0]  m_pfn [N];
  bit              m_ro [N];
  int              m_ptr = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < N; i++) m_v[i] = 0;
  endtask

  task automatic do_fill(input int vpn, input int asid, input int pfn, input bit ro);
    int idx;
    @(negedge clk);
    fill_valid = 1; fill_vpn = VPN_W'(vpn); fill_asid = ASID_W'(asid);
    fill_pfn = PFN_W'(pfn); fill_ro = ro;
    @(negedge clk);
    fill_valid = 0;
    idx = -1;
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == VPN_W'(vpn) && m_asid[i] == ASID_W'(asid)) idx = i;
    if (idx < 0)
      for (int i = N - 1; i >= 0; i--) if (!m_v[i]) idx = i;
    if (idx < 0) begin idx = m_ptr; m_ptr = (m_ptr + 1) % N; end
    m_v[idx] = 1; m_vpn[idx] = VPN_W'(vpn); m_asid[idx] = ASID_W'(asid);
    m_pfn[idx] = PFN_W'(pfn); m_ro[idx] = ro;
  endtask

  // Lookup on both instances; the tagged one is checked against the model.
  task automatic do_look(input int vpn, input int asid, input bit wr, input string req);
    int code, exp_code, exp_pfn;
    @(negedge clk);
    lk_valid = 1; lk_vpn = VPN_W'(vpn); lk_asid = ASID_W'(asid); lk_write = wr;
    @(negedge clk);
    lk_valid = 0; lk_write = 0;
    exp_code = 1; exp_pfn = 0;   // code: 1 miss, 2 hit, 4 fault
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == VPN_W'(vpn) && m_asid[i] == ASID_W'(asid)) begin
        if (wr && m_ro[i]) exp_code = 4;
        else begin exp_code = 2; exp_pfn = m_pfn[i]; end
      end
    code = {rsp_fault, rsp_hit, rsp_miss};
    check(rsp_valid && code == exp_code, req, "outcome", code, exp_code);
    check(rsp_pfn == PFN_W'(exp_pfn), req, "frame", rsp_pfn, exp_pfn);
  endtask

  task automatic do_flush_all();
    @(negedge clk); flush_all = 1;
    @(negedge clk); flush_all = 0;
    model_clear();
  endtask

  task automatic t_reset();
    check(!rsp_valid && !rsp_hit && !rsp_fault, "R1", "idle response after reset",
          {rsp_valid, rsp_hit, rsp_fault}, 0);
    do_look(12'h123, 1, 0, "R1");
    check(!n_hit && n_miss, "R1", "untagged empty miss", n_hit, 0);
    @(negedge clk);
    check(!rsp_valid, "R2", "valid only one cycle", rsp_valid, 0);
  endtask

  task automatic t_basic();
    do_fill('h10, 1, 'hA10, 0);
    do_fill('h11, 1, 'hA11, 0);
    do_look('h10, 1, 0, "R3");
    do_look('h11, 1, 1, "R3");
    do_look('h12, 1, 0, "R3");
  endtask

  task automatic t_asid();
    do_look('h10, 2, 0, "R4");
    do_fill('h10, 2, 'hB10, 0);
    do_look('h10, 2, 0, "R4");
    do_look('h10, 1, 0, "R4");
  endtask

  task automatic t_readonly();
    do_fill('h20, 1, 'hC20, 1);
    do_look('h20, 1, 0, "R5");
    do_look('h20, 1, 1, "R5");
  endtask

  task automatic t_overwrite();
    do_flush_all();
    do_fill('h30, 1, 'h111, 0);
    do_fill('h30, 1, 'h222, 1);
    for (int k = 1; k < N; k++) do_fill('h30 + k, 1, 'h300 + k, 0);
    for (int k = 0; k < N; k++) do_look('h30 + k, 1, 0, "R8");
    do_look('h30, 1, 1, "R8");
  endtask

  task automatic t_roundrobin();
    do_flush_all();
    for (int k = 0; k < N; k++) do_fill('h100 + k, 1, 'h500 + k, 0);
    do_fill('h108, 1, 'h508, 0);
    do_fill('h109, 1, 'h509, 0);
    for (int k = 0; k < N + 2; k++) do_look('h100 + k, 1, 0, "R7");
  endtask

  task automatic t_tagflush();
    do_flush_all();
    for (int k = 0; k < N; k++) do_fill('h200 + k, (k == 1 || k == 3) ? 2 : 1, 'h600 + k, 0);
    @(negedge clk); flush_asid_valid = 1; flush_asid = 2;
    @(negedge clk); flush_asid_valid = 0;
    for (int i = 0; i < N; i++) if (m_asid[i] == 2) m_v[i] = 0;
    for (int k = 0; k < N; k++) do_look('h200 + k, (k == 1 || k == 3) ? 2 : 1, 0, "R10");
    do_fill('h300, 1, 'h700, 0);
    do_fill('h301, 1, 'h701, 0);
    do_fill('h302, 1, 'h702, 0);
    for (int k = 0; k < N; k++) do_look('h200 + k, 1, 0, "R6");
    for (int k = 0; k < 3; k++) do_look('h300 + k, 1, 0, "R6");
  endtask

  task automatic t_flush_with_fill();
    @(negedge clk);
    flush_all = 1; fill_valid = 1; fill_vpn = 'h400; fill_asid = 1; fill_pfn = 'h800; fill_ro = 0;
    @(negedge clk);
    flush_all = 0; fill_valid = 0;
    model_clear();
    do_look('h400, 1, 0, "R9");
    do_look('h300, 1, 0, "R9");
  endtask

  task automatic t_ctx();
    do_fill('h500, 3, 'h900, 0);
    @(negedge clk);
    lk_valid = 1; lk_vpn = 'h500; lk_asid = 5; lk_write = 0;
    @(negedge clk);
    lk_valid = 0;
    check(rsp_miss, "R11", "tagged other tag misses", rsp_miss, 1);
    check(n_hit && n_pfn == 'h900, "R11", "untagged ignores tag", n_pfn, 'h900);
    @(negedge clk); ctx_switch = 1;
    @(negedge clk); ctx_switch = 0;
    do_look('h500, 3, 0, "R11");
    check(n_miss, "R11", "untagged flushed by context switch", n_miss, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_clear();
    t_reset();
    t_basic();
    t_asid();
    t_readonly();
    t_overwrite();
    t_roundrobin();
    t_tagflush();
    t_flush_with_fill();
    t_ctx();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule